// File: doc/BRIEF.md
# E1 Timing Status Flag Register

This block turns the periodic timing events and clock-activity checks of an E1 framer into one 8-bit sticky status byte for a host. The framer's receive and transmit sides supply single-cycle strobes for frame starts, for align-frame qualification and for multiframe boundaries. From these strobes the block raises flags that show the host when align-frame bits, signalling data or multiframe updates are due. The block also derives a one-second tick and a free-running 2 ms boundary by counting rising edges of the receive clock. It watches the transmit clock against the receive clock, and the receive clock against the block clock, so that it can report when either clock has stopped.

The whole block runs on one free-running reference clock (the block clock, at least 8 MHz). The receive and transmit line clocks arrive as levels already sampled into that domain. The host reads the byte. A read pulse clears the flags that the host has just seen and keeps any event that arrives in the same cycle. When its enable is high, an alarm pin follows the transmit-clock-loss condition.

Top module: `e1_tstat_reg`

## Requirements
- R1: After reset the status byte is 0x00 and the alarm pin is low. The bit layout, from bit 7 down to bit 0, is: receive CAS multiframe, receive align, transmit multiframe, one-second, transmit align, transmit clock lost, receive CRC4 multiframe, receive clock lost.
- R2: Bit 7 is set one cycle after `rx_cas_mf_i` is sampled high. No CAS enable gates this flag.
- R3: Bit 6 is set one cycle after `rx_fs_i` and `rx_align_i` are both sampled high. Bit 3 is set in the same way from `tx_fs_i` and `tx_align_i`. A frame start with its align input low sets neither flag.
- R4: Bit 5 is set one cycle after `tx_mf_i` is sampled high, whatever the value of `crc4_en_i`.
- R5: Bit 4 is set one cycle after every SEC_EDGES-th rising edge of `rclk_i`, counted from reset.
- R6: Bit 2 is set one cycle after `tclk_i` has shown no transition over TLOSS_EDGES rising edges of `rclk_i`. It keeps being set while the transmit clock stays quiet.
- R7: `alarm_o` is high exactly while `alarm_en_i` is high and the transmit clock has been quiet for TLOSS_EDGES receive clock rising edges. A transition on `tclk_i` releases it at the next cycle.
- R8: Bit 1 is set one cycle after `rx_crc_mf_i` is sampled high while `crc4_en_i` is 1. While `crc4_en_i` is 0 the bit instead follows every MF_EDGES-th rising edge of `rclk_i`, counted from reset, and `rx_crc_mf_i` is ignored.
- R9: Bit 0 is set one cycle after `rclk_i` has held its level for RLOSS_REF block-clock cycles. It keeps being set while the receive clock stays stuck.
- R10: Flags are sticky. A cycle with `rd_i` high clears every bit that was set, and an event that arrives in the same cycle as the read is set again and held for the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rclk_i | input | 1 | Receive line clock, sampled level |
| tclk_i | input | 1 | Transmit line clock, sampled level |
| rx_fs_i | input | 1 | Receive frame-start strobe |
| rx_align_i | input | 1 | Current receive frame is an align frame |
| tx_fs_i | input | 1 | Transmit frame-start strobe |
| tx_align_i | input | 1 | Current transmit frame is an align frame |
| rx_cas_mf_i | input | 1 | Receive CAS multiframe boundary strobe |
| rx_crc_mf_i | input | 1 | Receive CRC4 multiframe boundary strobe |
| tx_mf_i | input | 1 | Transmit multiframe boundary strobe |
| crc4_en_i | input | 1 | CRC4 framing enabled |
| rd_i | input | 1 | Host read pulse, clears the flags it returns |
| alarm_en_i | input | 1 | Enable for the transmit-clock-loss alarm pin |
| status_o | output | 8 | Sticky status byte |
| alarm_o | output | 1 | Transmit-clock-loss alarm pin |

## Verification
Every strobe-driven flag, and both divided ticks, show on `status_o` one block-clock cycle after the edge that samples the causing input. The loss flags show one cycle after their quiet counter reaches its limit, while `alarm_o` changes in the same cycle as that counter. The bench drives inputs just after a falling edge and compares every bit and the alarm pin at the next falling edge. Its reference model advances at the rising edge between the two, so each comparison lands exactly one register stage after the stimulus.

// File: rtl/e1ts_pkg.sv
package e1ts_pkg;
    localparam int FLAG_W     = 8;
    // bit positions of the host status byte (host decodes these)
    localparam int B_RX_CAS   = 7;
    localparam int B_RX_ALIGN = 6;
    localparam int B_TX_MF    = 5;
    localparam int B_SEC      = 4;
    localparam int B_TX_ALIGN = 3;
    localparam int B_TCLK_LOS = 2;
    localparam int B_RX_CRC   = 1;
    localparam int B_RCLK_LOS = 0;

    typedef logic [FLAG_W-1:0] flags_t;
endpackage

// File: rtl/e1ts_div.sv
module e1ts_div #(
    parameter int PERIOD = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = $clog2(PERIOD + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_q, s_d;
    logic last;

    assign last   = (s_q.cnt == CW'(PERIOD - 1));
    assign tick_o = en_i && last;

    always_comb begin
        s_d = s_q;
        if (en_i) begin
            s_d.cnt = last ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < CW'(PERIOD)); // R5
    AST_DIV_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (s_q.cnt == '0)); // R8
endmodule

// File: rtl/e1ts_clk_mon.sv
module e1ts_clk_mon #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic cnt_en_i,
    output logic lost_o
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
    } st_t;

    st_t  s_q, s_d;
    logic toggle;

    assign toggle = (sig_i != s_q.prev);
    assign lost_o = (s_q.cnt == CW'(LIMIT));

    always_comb begin
        s_d      = s_q;
        s_d.prev = sig_i;
        if (toggle) begin
            s_d.cnt = '0;
        end else if (cnt_en_i && !lost_o) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_MON_TOGGLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> !lost_o); // R6
    AST_MON_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(LIMIT)); // R9
endmodule

// File: rtl/e1_tstat_reg.sv
module e1_tstat_reg
    import e1ts_pkg::*;
#(
    parameter int SEC_EDGES   = 2048000,
    parameter int MF_EDGES    = 4096,
    parameter int TLOSS_EDGES = 8,
    parameter int RLOSS_REF   = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rclk_i,
    input  logic        tclk_i,
    input  logic        rx_fs_i,
    input  logic        rx_align_i,
    input  logic        tx_fs_i,
    input  logic        tx_align_i,
    input  logic        rx_cas_mf_i,
    input  logic        rx_crc_mf_i,
    input  logic        tx_mf_i,
    input  logic        crc4_en_i,
    input  logic        rd_i,
    input  logic        alarm_en_i,
    output logic [7:0]  status_o,
    output logic        alarm_o
);
    typedef struct packed {
        flags_t flags;
        logic   rck_prev;
    } st_t;

    st_t    s_q, s_d;
    logic   rck_rise, sec_tick, mf_tick, tlost, rlost;
    flags_t ev;

    assign rck_rise = rclk_i & ~s_q.rck_prev;

    e1ts_div #(.PERIOD(SEC_EDGES)) u_sec (
        .clk(clk), .rst_n(rst_n), .en_i(rck_rise), .tick_o(sec_tick));

    e1ts_div #(.PERIOD(MF_EDGES)) u_mf (
        .clk(clk), .rst_n(rst_n), .en_i(rck_rise), .tick_o(mf_tick));

    // transmit clock quiet time is measured in receive clock edges
    e1ts_clk_mon #(.LIMIT(TLOSS_EDGES)) u_tmon (
        .clk(clk), .rst_n(rst_n), .sig_i(tclk_i), .cnt_en_i(rck_rise), .lost_o(tlost));

    // receive clock quiet time is measured in block clock cycles
    e1ts_clk_mon #(.LIMIT(RLOSS_REF)) u_rmon (
        .clk(clk), .rst_n(rst_n), .sig_i(rclk_i), .cnt_en_i(1'b1), .lost_o(rlost));

    always_comb begin
        ev             = '0;
        ev[B_RX_CAS]   = rx_cas_mf_i;
        ev[B_RX_ALIGN] = rx_fs_i & rx_align_i;
        ev[B_TX_MF]    = tx_mf_i;
        ev[B_SEC]      = sec_tick;
        ev[B_TX_ALIGN] = tx_fs_i & tx_align_i;
        ev[B_TCLK_LOS] = tlost;
        ev[B_RX_CRC]   = crc4_en_i ? rx_crc_mf_i : mf_tick;
        ev[B_RCLK_LOS] = rlost;

        s_d          = s_q;
        s_d.rck_prev = rclk_i;
        s_d.flags    = (rd_i ? flags_t'('0) : s_q.flags) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status_o = s_q.flags;
    assign alarm_o  = alarm_en_i & tlost;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> ((s_q.flags & $past(s_q.flags)) == $past(s_q.flags))); // R10
    AST_ALARM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |=> s_q.flags[B_TCLK_LOS]); // R7
    AST_CAS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cas_mf_i |=> s_q.flags[B_RX_CAS]); // R2
    AST_TXMF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_mf_i |=> s_q.flags[B_TX_MF]); // R4
    AST_RXALIGN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fs_i && rx_align_i) |=> s_q.flags[B_RX_ALIGN]); // R3
endmodule

// File: tb/sim_e1_tstat_reg.sv
`timescale 1ns/1ps
module sim_e1_tstat_reg;
    localparam int SEC = 50;
    localparam int MF  = 12;
    localparam int TL  = 8;
    localparam int RL  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rclk = 0, tclk = 0, rx_fs = 0, rx_al = 0, tx_fs = 0, tx_al = 0;
    logic cas = 0, crcmf = 0, txmf = 0, crc_en = 0, rd = 0, al_en = 0;
    logic [7:0] status;
    logic alarm;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    e1_tstat_reg #(.SEC_EDGES(SEC), .MF_EDGES(MF), .TLOSS_EDGES(TL), .RLOSS_REF(RL)) u0 (
        .clk(clk), .rst_n(rst_n), .rclk_i(rclk), .tclk_i(tclk),
        .rx_fs_i(rx_fs), .rx_align_i(rx_al), .tx_fs_i(tx_fs), .tx_align_i(tx_al),
        .rx_cas_mf_i(cas), .rx_crc_mf_i(crcmf), .tx_mf_i(txmf), .crc4_en_i(crc_en),
        .rd_i(rd), .alarm_en_i(al_en), .status_o(status), .alarm_o(alarm));

    // reference model built from the requirements
    logic [7:0] m_flags;
    logic m_rprev, m_tprev;
    int m_sec, m_mf, m_tcnt, m_rcnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flags = 8'h00; m_rprev = 0; m_tprev = 0;
            m_sec = 0; m_mf = 0; m_tcnt = 0; m_rcnt = 0;
        end else begin
            logic rise;
            logic [7:0] ev;
            rise = rclk && !m_rprev;
            ev = 8'h00;
            ev[7] = cas;                                            // R2
            ev[6] = rx_fs && rx_al;                                 // R3
            ev[5] = txmf;                                           // R4
            ev[4] = rise && (m_sec == SEC - 1);                     // R5
            ev[3] = tx_fs && tx_al;                                 // R3
            ev[2] = (m_tcnt == TL);                                 // R6
            ev[1] = crc_en ? crcmf : (rise && (m_mf == MF - 1));    // R8
            ev[0] = (m_rcnt == RL);                                 // R9
            m_flags = (rd ? 8'h00 : m_flags) | ev;                  // R10
            if (rise) begin
                m_sec = (m_sec == SEC - 1) ? 0 : m_sec + 1;
                m_mf  = (m_mf == MF - 1) ? 0 : m_mf + 1;
            end
            if (tclk != m_tprev) m_tcnt = 0;
            else if (rise && m_tcnt < TL) m_tcnt++;
            if (rclk != m_rprev) m_rcnt = 0;
            else if (m_rcnt < RL) m_rcnt++;
            m_rprev = rclk;
            m_tprev = tclk;
        end
    end

    function automatic string tag_of(input int b);
        case (b)
            7: return "R2";
            6: return "R3";
            5: return "R4";
            4: return "R5";
            3: return "R3";
            2: return "R6";
            1: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        for (int b = 0; b < 8; b++)
            chk(tag_of(b), {7'd0, status[b]}, {7'd0, m_flags[b]});
        chk("R7", {7'd0, alarm}, {7'd0, al_en && (m_tcnt == TL)});
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    int rhold = 0;
    int thold = 0;

    task automatic rand_inputs(input int cyc);
        rx_fs = ($urandom % 8) == 0; rx_al = $urandom % 2;
        tx_fs = ($urandom % 8) == 0; tx_al = $urandom % 2;
        cas   = ($urandom % 16) == 0;
        crcmf = ($urandom % 10) == 0;
        txmf  = ($urandom % 16) == 0;
        rd    = ($urandom % 5) == 0;
        if (cyc % 150 == 0) crc_en = $urandom % 2;
        if (cyc % 97 == 0) al_en = $urandom % 2;
        if (cyc % 211 == 100) rhold = 9 + ($urandom % 4);
        if (cyc % 173 == 40)  thold = 30 + ($urandom % 20);
        if (rhold > 0) rhold--;
        else if (($urandom % 4) != 0) rclk = ~rclk;
        if (thold > 0) thold--;
        else if (($urandom % 8) != 0) tclk = ~tclk;
    endtask

    task automatic quiet();
        rx_fs = 0; tx_fs = 0; cas = 0; crcmf = 0; txmf = 0; rd = 0;
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", status, 8'h00);
        chk("R1", {7'd0, alarm}, 8'h00);
        rst_n = 1'b1;
        step();
        chk("R1", status, 8'h00);

        // directed: align frame qualification (R3)
        quiet(); rx_fs = 1; rx_al = 0; tx_fs = 1; tx_al = 0; rclk = ~rclk; tclk = ~tclk;
        step();
        chk("R3", {6'd0, status[6], status[3]}, 8'h00);
        quiet(); rx_fs = 1; rx_al = 1; tx_fs = 1; tx_al = 1; rclk = ~rclk; tclk = ~tclk;
        step();
        chk("R3", {6'd0, status[6], status[3]}, 8'h03);

        // directed: read clears, same-cycle event kept (R10)
        quiet(); rd = 1; cas = 1; rclk = ~rclk; tclk = ~tclk;
        step();
        chk("R10", {7'd0, status[7]}, 8'h01);
        chk("R10", {6'd0, status[6], status[3]}, 8'h00);
        quiet(); rd = 1; rclk = ~rclk; tclk = ~tclk;
        step();
        chk("R10", {7'd0, status[7]}, 8'h00);

        // directed: CRC4 strobe ignored while disabled (R8)
        quiet(); crc_en = 0; crcmf = 1; rd = 1; rclk = ~rclk; tclk = ~tclk;
        step();
        chk("R8", {7'd0, status[1]}, {7'd0, m_flags[1]});
        quiet(); crc_en = 1; crcmf = 1; rclk = ~rclk; tclk = ~tclk;
        step();
        chk("R8", {7'd0, status[1]}, 8'h01);

        // directed: stopped transmit clock raises alarm (R6, R7)
        quiet(); al_en = 1;
        for (int i = 0; i < 2 * TL + 2; i++) begin
            rclk = ~rclk;
            step();
        end
        chk("R7", {7'd0, alarm}, 8'h01);
        chk("R6", {7'd0, status[2]}, 8'h01);
        tclk = ~tclk;
        step();
        chk("R7", {7'd0, alarm}, 8'h00);

        // directed: stuck receive clock (R9)
        quiet(); rd = 1;
        for (int i = 0; i < RL + 2; i++) begin
            step();
            rd = 0;
        end
        chk("R9", {7'd0, status[0]}, 8'h01);

        // random phase, model-checked every cycle (R2..R10)
        for (int c = 1; c <= 3000; c++) begin
            rand_inputs(c);
            step();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule